// File: doc/BRIEF.md
# Four-Phase Tone Cadence Controller

The controller sequences one supervisory tone through a repeating cadence of four programmable periods, visited in the fixed order 0, 1, 2, 3, then back to 0. Each period length is a 10-bit count of 5 ms ticks, so one period lasts at most 5115 ms. The controller reports whether the tone is currently audible, which of two 4-bit waveform block numbers applies, and the index of the running period. Periods 0 and 2 are audible: period 0 uses block A and period 2 uses block B. Periods 1 and 3 are silent. A period with a duration of zero is skipped. A tone whose only nonzero duration is period 0 therefore plays without a break.

A tone generator uses one instance per tone stream, nine in all: eight sample streams and one square-wave tone whose on/off output drives a pin. The surrounding logic supplies a one-cycle enable at 200 Hz and a synchronous `start` pulse that restarts the cadence from period 0.

The control is a three-state machine. **SEEK** lasts one cycle after reset or `start`. In that cycle it searches from period 0 for the first nonzero duration. Transition *seek-hit* loads that duration and enters **COUNT**. Transition *seek-miss* enters **HALT** when all four durations are zero. In **COUNT**, each tick decrements the period timer. On the tick that ends a period, transition *expire-advance* searches the following periods cyclically and loads the first nonzero one. That search includes the current period as the last candidate. If every duration has become zero, transition *expire-miss* enters **HALT**. **HALT** keeps the tone off until *restart*. The *restart* transition is taken from any state on `start` and leads to SEEK.

Top module: `tone_cadence_seq`

## Requirements
- R1: While reset is asserted and directly after it, `phase` is 0, `tone_on` is 0 and `blk_sel` equals `blk_a`. The first clock after reset is the SEEK cycle.
- R2: A period entered with duration N stays current for exactly N ticks and changes on the N-th tick. N = 1023 is valid.
- R3: Periods with nonzero durations follow one another in the cyclic order 0, 1, 2, 3, 0.
- R4: A period whose duration is zero is never entered. Both the SEEK search and the search at expiry pass over it.
- R5: `tone_on` is 1 exactly when the state is COUNT and `phase` is 0 or 2. It is 0 in periods 1 and 3, in SEEK and in HALT.
- R6: `blk_sel` equals `blk_b` when `phase` is 2 and equals `blk_a` for every other phase value.
- R7: With durations N,0,0,0 (N nonzero), the controller reloads period 0 at each expiry and the tone stays on indefinitely.
- R8: If all four durations are zero, the controller enters HALT with `phase` 0 and the tone off. It stays there, whatever the durations and ticks do, until `start`.
- R9: `start` forces SEEK with `phase` 0 on the next clock and wins over a tick that would end a period in the same cycle. The restarted period then runs its full length.
- R10: A duration is captured when its period is entered. Changing it during the period does not alter that period's length.
- R11: Without a tick, `phase` and state do not change. A tick that arrives in the SEEK cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous restart from period 0 |
| tick | input | 1 | One-cycle 5 ms timebase enable |
| dur0 | input | DUR_W | Length of period 0 (audible, block A), in ticks |
| dur1 | input | DUR_W | Length of period 1 (silent), in ticks |
| dur2 | input | DUR_W | Length of period 2 (audible, block B), in ticks |
| dur3 | input | DUR_W | Length of period 3 (silent), in ticks |
| blk_a | input | BLK_W | Waveform block number for period 0 |
| blk_b | input | BLK_W | Waveform block number for period 2 |
| tone_on | output | 1 | Tone audible in the current period |
| blk_sel | output | BLK_W | Waveform block number for the current period |
| phase | output | 2 | Index of the current period |

## Verification
Two events can fall in the same cycle: the restart requested by `start` and the expiry of a period by its final tick. The bench provokes this by raising `start` and `tick` together on the tick that would otherwise move period 0 into period 1. It then checks that `phase` reads 0 with the tone off for the SEEK cycle. It also checks that the restarted period 0 needs its full two ticks before period 1 appears, which shows that the timer was reloaded and did not carry the old count. A second collision, a tick during the SEEK cycle, is judged by showing that the first period still needs all of its ticks.

// File: rtl/cad_pkg.sv
package cad_pkg;
    localparam int NUM_PH = 4;
    localparam int PH_W   = $clog2(NUM_PH);
    localparam int PH_B   = 2;

    typedef enum logic [1:0] {
        ST_SEEK  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2
    } cad_state_e;
endpackage

// File: rtl/cad_pick.sv
module cad_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  live,
    input  logic [IW-1:0] from,
    output logic          hit,
    output logic [IW-1:0] pick
);
    // Cyclic priority search: the candidate nearest to 'from' wins.
    always_comb begin
        hit  = 1'b0;
        pick = from;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(from) + k) % N;
            if (live[idx]) begin
                hit  = 1'b1;
                pick = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/cad_timer.sv
module cad_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - W'(1);
    end

    assign last = (cnt == W'(1));

    // R2: decrement is only requested above the final count
    a_r2_dec_above_one: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt > W'(1)));
endmodule

// File: rtl/tone_cadence_seq.sv
module tone_cadence_seq #(
    parameter int DUR_W = 10,
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [DUR_W-1:0] dur0,
    input  logic [DUR_W-1:0] dur1,
    input  logic [DUR_W-1:0] dur2,
    input  logic [DUR_W-1:0] dur3,
    input  logic [BLK_W-1:0] blk_a,
    input  logic [BLK_W-1:0] blk_b,
    output logic             tone_on,
    output logic [BLK_W-1:0] blk_sel,
    output logic [1:0]       phase
);
    import cad_pkg::*;

    cad_state_e        state_q, state_d;
    logic [PH_W-1:0]   phase_q, phase_d;
    logic [DUR_W-1:0]  dur_arr [NUM_PH];
    logic [NUM_PH-1:0] live;
    logic [PH_W-1:0]   pick_from, pick_idx;
    logic              pick_hit;
    logic              tmr_load, tmr_dec, tmr_last;
    logic [DUR_W-1:0]  tmr_cnt, load_val;

    assign dur_arr[0] = dur0;
    assign dur_arr[1] = dur1;
    assign dur_arr[2] = dur2;
    assign dur_arr[3] = dur3;

    generate
        for (genvar g = 0; g < NUM_PH; g++) begin : g_live
            assign live[g] = |dur_arr[g];
        end
    endgenerate

    // SEEK searches from the current (reset) period, expiry from the next one.
    assign pick_from = (state_q == ST_SEEK) ? phase_q
                                            : PH_W'((int'(phase_q) + 1) % NUM_PH);

    cad_pick #(.N(NUM_PH), .IW(PH_W)) u_pick (
        .live (live),
        .from (pick_from),
        .hit  (pick_hit),
        .pick (pick_idx)
    );

    assign load_val = dur_arr[pick_idx];

    cad_timer #(.W(DUR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (load_val),
        .dec      (tmr_dec),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        if (start) begin
            state_d = ST_SEEK;
            phase_d = '0;
        end else begin
            unique case (state_q)
                ST_SEEK: begin
                    if (pick_hit) begin
                        state_d  = ST_COUNT;
                        phase_d  = pick_idx;
                        tmr_load = 1'b1;
                    end else begin
                        state_d = ST_HALT;
                        phase_d = '0;
                    end
                end
                ST_COUNT: begin
                    if (tick) begin
                        if (!tmr_last) begin
                            tmr_dec = 1'b1;
                        end else if (pick_hit) begin
                            phase_d  = pick_idx;
                            tmr_load = 1'b1;
                        end else begin
                            state_d = ST_HALT;
                            phase_d = '0;
                        end
                    end
                end
                ST_HALT: begin
                    state_d = ST_HALT;
                end
                default: begin
                    state_d = ST_SEEK;
                    phase_d = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // Outputs
    always_comb begin
        tone_on = (state_q == ST_COUNT) && !phase_q[0];
        blk_sel = (phase_q == PH_W'(PH_B)) ? blk_b : blk_a;
        phase   = phase_q;
    end

    // R4: a period that is entered never has a zero duration
    a_r4_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |-> (load_val != '0));

    // R2: the timer holds a live count whenever a period runs
    a_r2_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (tmr_cnt != '0));

    // R11: without a tick or start, a running period holds
    a_r11_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !tick && !start) |=> ($stable(phase) && state_q == ST_COUNT));

    // R9: start always restarts from period 0 with the tone off
    a_r9_start_seek: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_SEEK && phase == 2'd0 && !tone_on));

    // R8: halt persists until start
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !start) |=> (state_q == ST_HALT && !tone_on));
endmodule

// File: tb/tone_cadence_seq_test.sv
module tone_cadence_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic [9:0] dur0 = '0, dur1 = '0, dur2 = '0, dur3 = '0;
    logic [3:0] blk_a = 4'h5, blk_b = 4'hA;
    logic       tone_on;
    logic [3:0] blk_sel;
    logic [1:0] phase;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tone_cadence_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .dur0(dur0), .dur1(dur1), .dur2(dur2), .dur3(dur3),
        .blk_a(blk_a), .blk_b(blk_b),
        .tone_on(tone_on), .blk_sel(blk_sel), .phase(phase)
    );

    typedef struct packed {
        logic [9:0] d0, d1, d2, d3;
        logic [7:0] nt;
        logic [1:0] ph;
        logic       on;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{10'd3, 10'd2, 10'd4, 10'd1, 8'd0,  2'd0, 1'b1},
        '{10'd3, 10'd2, 10'd4, 10'd1, 8'd2,  2'd0, 1'b1},
        '{10'd3, 10'd2, 10'd4, 10'd1, 8'd3,  2'd1, 1'b0},
        '{10'd3, 10'd2, 10'd4, 10'd1, 8'd5,  2'd2, 1'b1},
        '{10'd3, 10'd2, 10'd4, 10'd1, 8'd9,  2'd3, 1'b0},
        '{10'd3, 10'd2, 10'd4, 10'd1, 8'd10, 2'd0, 1'b1},
        '{10'd2, 10'd0, 10'd3, 10'd0, 8'd2,  2'd2, 1'b1},
        '{10'd2, 10'd0, 10'd3, 10'd0, 8'd5,  2'd0, 1'b1},
        '{10'd0, 10'd4, 10'd0, 10'd1, 8'd0,  2'd1, 1'b0},
        '{10'd0, 10'd4, 10'd0, 10'd1, 8'd4,  2'd3, 1'b0},
        '{10'd0, 10'd4, 10'd0, 10'd1, 8'd5,  2'd1, 1'b0},
        '{10'd5, 10'd0, 10'd0, 10'd0, 8'd17, 2'd0, 1'b1},
        '{10'd0, 10'd0, 10'd0, 10'd0, 8'd3,  2'd0, 1'b0},
        '{10'd1, 10'd1, 10'd1, 10'd1, 8'd6,  2'd2, 1'b1}
    };

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic check_out(input string req, input int eph, input int eon);
        check(req, "phase", int'(phase), eph);
        check(req, "tone_on", int'(tone_on), eon);
        check("R6", "blk_sel", int'(blk_sel), (eph == 2) ? int'(blk_b) : int'(blk_a));
    endtask

    task automatic set_dur(input int a, input int b, input int c, input int d);
        dur0 = 10'(a); dur1 = 10'(b); dur2 = 10'(c); dur3 = 10'(d);
    endtask

    // start pulse, then let the SEEK cycle pass
    task automatic restart();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_out("R1", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 0, 0);

        // Table: R3, R4, R5, R7, R8 under several cadences
        for (int v = 0; v < NV; v++) begin
            set_dur(int'(TBL[v].d0), int'(TBL[v].d1), int'(TBL[v].d2), int'(TBL[v].d3));
            restart();
            ticks(int'(TBL[v].nt));
            check_out("R3/R4/R5 table", int'(TBL[v].ph), int'(TBL[v].on));
        end

        // R2: maximum duration boundary
        set_dur(1023, 1, 0, 0);
        restart();
        ticks(1022);
        check_out("R2 before end", 0, 1);
        ticks(1);
        check_out("R2 at end", 1, 0);

        // R10: change duration mid-period
        set_dur(4, 3, 0, 0);
        restart();
        ticks(2);
        dur0 = 10'd9;
        ticks(1);
        check_out("R10 mid", 0, 1);
        ticks(1);
        check_out("R10 end", 1, 0);

        // R11: no ticks, phase holds
        repeat (10) @(negedge clk);
        check_out("R11 idle", 1, 0);

        // R9: start collides with the expiring tick
        set_dur(2, 3, 0, 0);
        restart();
        ticks(1);
        start = 1'b1; tick = 1'b1;
        @(negedge clk) begin start = 1'b0; tick = 1'b0; end
        check_out("R9 seek", 0, 0);
        @(negedge clk);
        check_out("R9 restarted", 0, 1);
        ticks(1);
        check_out("R9 full length", 0, 1);
        ticks(1);
        check_out("R9 advance", 1, 0);

        // R11: tick during SEEK is ignored
        set_dur(2, 1, 0, 0);
        @(negedge clk) start = 1'b1;
        @(negedge clk) begin start = 1'b0; tick = 1'b1; end
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
        ticks(1);
        check_out("R11 seek tick", 0, 1);
        ticks(1);
        check_out("R11 seek tick", 1, 0);

        // R8: halt persists until start
        set_dur(0, 0, 0, 0);
        restart();
        set_dur(1, 1, 0, 0);
        ticks(4);
        check_out("R8 sticky", 0, 0);
        restart();
        check_out("R8 recover", 0, 1);

        // R7: continuous tone across many expiries
        set_dur(2, 0, 0, 0);
        restart();
        for (int i = 0; i < 5; i++) begin
            ticks(1);
            check_out("R7 continuous", 0, 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule